// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block holds the request, in-service and mask state for eight interrupt levels and decides when the CPU is interrupted. Request lines are captured either on a rising edge or as a live level. Masked levels are removed, and a rotating scan picks the highest-priority candidate, which appears on `win_level`. A small state machine then drives `irq_out`. An acknowledge strobe moves the winning level from pending to in-service. Decoded end-of-interrupt and rotation commands clear in-service bits and move the lowest-priority slot of the ring.

Priority is held as a three-bit pointer to the lowest-priority level. The scan starts at the pointer plus one and wraps modulo eight, so the level just after the pointer is the highest. In nested operation an in-service bit blocks its own level and every level below it. In special mask mode an in-service bit blocks only its own level.

The interrupt state machine has two states, ST_IDLE and ST_ASSERT. On each clock it goes from ST_IDLE to ST_ASSERT when an eligible request exists, and from ST_ASSERT back to ST_IDLE when none remains. Otherwise it stays where it is. `irq_out` is high exactly in ST_ASSERT.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset the pointer is 7, so level 0 is highest. `irr_out`, `isr_out`, the mask and `irq_out` are all zero. In edge mode, a line held high through reset is not a request until it has gone low and then high again.
- R2: In edge mode (`level_mode`=0), a rising edge on `req_in[k]` sets `irr_out[k]` one clock later. The bit stays set after the line falls, until that level is acknowledged.
- R3: In level mode (`level_mode`=1), `irr_out` equals `req_in` delayed by one clock. A line that falls removes its request.
- R4: A mask bit of 1, loaded by `mask_wr` with `mask_data`, stops that level from winning or raising `irq_out`. A mask bit of 0 lets the level take part.
- R5: When `ack` is high while a request is eligible, the clock sets `isr_out[win_level]`. In edge mode the same clock clears `irr_out[win_level]`.
- R6: Outside special mask mode, a request is eligible only when its rank is strictly higher than the rank of every set in-service bit. A pending request at an equal or lower level than an in-service one leaves `irq_out` low.
- R7: `cmd_op`=1 (non-specific end) clears the highest-priority set bit of `isr_out`.
- R8: `cmd_op`=2 (specific end) clears `isr_out[cmd_level]`.
- R9: `cmd_op`=3 (rotate on non-specific end) clears the highest-priority in-service bit and makes that level the lowest. For example, after level 4 is cleared, level 5 is the highest.
- R10: `cmd_op`=5 (set priority) makes `cmd_level` the lowest level and leaves `isr_out` unchanged. `cmd_op`=4 (rotate on specific end) clears `isr_out[cmd_level]` and makes that level the lowest. Other `cmd_op` codes do nothing.
- R11: With `smm`=1, any request that is neither masked nor in service is eligible, whatever its rank against the in-service levels.
- R12: `irq_out` is registered: it shows the eligibility computed in the previous clock and falls once no eligible request remains. `win_level` gives the highest-ranked candidate under the rotating scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Request lines, one per level |
| level_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| mask_wr | input | 1 | Load strobe for the mask |
| mask_data | input | 8 | New mask value, 1 = level blocked |
| ack | input | 1 | Acknowledge strobe from the CPU side |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 nonspecific end, 2 specific end, 3 rotate nonspecific, 4 rotate specific, 5 set priority |
| cmd_level | input | 3 | Level operand of the command |
| smm | input | 1 | Special mask mode select |
| irq_out | output | 1 | Interrupt request to the CPU |
| win_level | output | 3 | Highest-ranked candidate level |
| irr_out | output | 8 | Request register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
The bench builds the block with its default parameters: eight levels and a three-bit level field. This keeps the configuration small enough to sweep in full. It walks every level through capture, acknowledge and specific end, and it loads all 256 mask values against a full set of level-mode requests. It moves the lowest-priority pointer to each of the eight positions with both the set-priority and the rotate-specific commands. Directed sequences cover nested blocking at equal and lower rank, rotation after a non-specific end, and special mask mode.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_NSEOI  = 3'd1,
        CMD_SPEOI  = 3'd2,
        CMD_ROTNS  = 3'd3,
        CMD_ROTSP  = 3'd4,
        CMD_SETPRI = 3'd5
    } cmd_e;

    typedef enum logic {
        ST_IDLE,
        ST_ASSERT
    } irq_st_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic         level_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] rise;

    assign rise = req_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;   // lines high at reset must fall before counting
            irr_q  <= '0;
        end else begin
            prev_q <= req_in;
            if (level_mode)
                irr_q <= req_in;
            else
                irr_q <= (irr_q & ~clr) | rise;
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] low_ptr,
    output logic          found,
    output logic [LW-1:0] lvl,
    output logic [LW-1:0] rank
);
    always_comb begin
        int idx;
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        idx   = 0;
        // scan from lowest rank to highest so the last hit is the best one
        for (int i = N - 1; i >= 0; i--) begin
            idx = (int'(low_ptr) + 1 + i) % N;
            if (vec[idx]) begin
                found = 1'b1;
                lvl   = LW'(idx);
                rank  = LW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_in,
    input  logic          level_mode,
    input  logic          mask_wr,
    input  logic [N-1:0]  mask_data,
    input  logic          ack,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [LW-1:0] cmd_level,
    input  logic          smm,
    output logic          irq_out,
    output logic [LW-1:0] win_level,
    output logic [N-1:0]  irr_out,
    output logic [N-1:0]  isr_out
);
    localparam logic [LW-1:0] PTR_RST = LW'(N - 1);

    logic [N-1:0]  irr;
    logic [N-1:0]  imr_q;
    logic [N-1:0]  isr_q;
    logic [LW-1:0] ptr_q;
    logic [N-1:0]  cand;
    logic          c_found, i_found;
    logic [LW-1:0] c_lvl, i_lvl, c_rank, i_rank;
    logic          elig;
    logic          ack_hit;
    logic [N-1:0]  set_vec;
    logic [N-1:0]  clr_isr;
    logic [LW-1:0] ptr_n;
    irq_st_e       state_q, state_n;
    cmd_e          op;

    irq_req_latch #(.N(N)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .level_mode(level_mode),
        .clr       (set_vec),
        .irr       (irr)
    );

    assign cand = smm ? (irr & ~imr_q & ~isr_q) : (irr & ~imr_q);

    irq_prio_pick #(.N(N), .LW(LW)) u_pick_req (
        .vec    (cand),
        .low_ptr(ptr_q),
        .found  (c_found),
        .lvl    (c_lvl),
        .rank   (c_rank)
    );

    irq_prio_pick #(.N(N), .LW(LW)) u_pick_isr (
        .vec    (isr_q),
        .low_ptr(ptr_q),
        .found  (i_found),
        .lvl    (i_lvl),
        .rank   (i_rank)
    );

    assign elig    = c_found && (smm || !i_found || (c_rank < i_rank));
    assign ack_hit = ack && elig;

    always_comb begin
        set_vec        = '0;
        set_vec[c_lvl] = ack_hit;
    end

    assign op = cmd_e'(cmd_op);

    always_comb begin
        clr_isr = '0;
        ptr_n   = ptr_q;
        if (cmd_valid) begin
            case (op)
                CMD_NSEOI: begin
                    clr_isr[i_lvl] = i_found;
                end
                CMD_SPEOI: begin
                    clr_isr[cmd_level] = 1'b1;
                end
                CMD_ROTNS: begin
                    clr_isr[i_lvl] = i_found;
                    if (i_found) ptr_n = i_lvl;
                end
                CMD_ROTSP: begin
                    clr_isr[cmd_level] = 1'b1;
                    ptr_n              = cmd_level;
                end
                CMD_SETPRI: begin
                    ptr_n = cmd_level;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q <= '0;
            isr_q <= '0;
            ptr_q <= PTR_RST;
        end else begin
            if (mask_wr) imr_q <= mask_data;
            isr_q <= (isr_q & ~clr_isr) | set_vec;
            ptr_q <= ptr_n;
        end
    end

    // interrupt state machine
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (elig)  state_n = ST_ASSERT;
            ST_ASSERT: if (!elig) state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        irq_out   = (state_q == ST_ASSERT);
        win_level = c_lvl;
        irr_out   = irr;
        isr_out   = isr_q;
    end
endmodule

// File: rtl/prio_irq_resolver_chk.sv
module prio_irq_resolver_chk #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [LW-1:0] cmd_level,
    input logic          smm,
    input logic          elig,
    input logic [N-1:0]  imr,
    input logic [N-1:0]  irr_out,
    input logic [N-1:0]  isr_out,
    input logic [LW-1:0] win_level,
    input logic          irq_out
);
    a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && elig) |=> isr_out[$past(win_level)]);

    a_r8_speoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && !(ack && elig && win_level == cmd_level))
        |=> !isr_out[$past(cmd_level)]);

    a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        elig |-> (!imr[win_level] && irr_out[win_level]));

    a_r6_nested_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (elig && !smm) |-> !isr_out[win_level]);

    a_r11_smm_excludes_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (elig && smm) |-> !isr_out[win_level]);

    a_r10_setprio_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5 && !ack) |=> $stable(isr_out));

    a_r12_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(elig)));
endmodule

bind prio_irq_resolver prio_irq_resolver_chk #(.N(N), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_level(cmd_level),
    .smm      (smm),
    .elig     (elig),
    .imr      (imr_q),
    .irr_out  (irr_out),
    .isr_out  (isr_out),
    .win_level(win_level),
    .irq_out  (irq_out)
);

// File: tb/sim_prio_irq_resolver.sv
`timescale 1ns/1ps
module sim_prio_irq_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = 8'h00;
    logic       level_mode = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = 8'h00;
    logic       ack = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_level = 3'd0;
    logic       smm = 1'b0;
    logic       irq_out;
    logic [2:0] win_level;
    logic [7:0] irr_out, isr_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .level_mode(level_mode),
        .mask_wr(mask_wr), .mask_data(mask_data), .ack(ack),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_level(cmd_level),
        .smm(smm), .irq_out(irq_out), .win_level(win_level),
        .irr_out(irr_out), .isr_out(isr_out)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_in = 8'h00; level_mode = 1'b0; mask_wr = 1'b0;
        ack = 1'b0; cmd_valid = 1'b0; smm = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic rise(int l);
        req_in[l] = 1'b1; step(1);
        req_in[l] = 1'b0; step(2);
    endtask

    task automatic do_ack();
        ack = 1'b1; step(1);
        ack = 1'b0; step(1);
    endtask

    task automatic do_cmd(int op, int lvl);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_level = 3'(lvl); step(1);
        cmd_valid = 1'b0; step(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: line 0 held high through reset
        rst_n = 1'b0; req_in = 8'h01;
        step(2);
        rst_n = 1'b1;
        step(3);
        chk("R1 irq after reset", int'(irq_out), 0);
        chk("R1 irr after reset", int'(irr_out), 0);
        chk("R1 isr after reset", int'(isr_out), 0);
        req_in = 8'h00; step(1);
        req_in = 8'h01; step(1);
        chk("R2 irr one clock after rise", int'(irr_out), 1);
        chk("R12 irq not yet raised", int'(irq_out), 0);
        step(1);
        chk("R12 irq raised", int'(irq_out), 1);
        chk("R1 level 0 wins", int'(win_level), 0);
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R5 isr set", int'(isr_out), 1);
        chk("R5 irr cleared with line high", int'(irr_out), 0);
        chk("R12 irq still high one clock", int'(irq_out), 1);
        step(1);
        chk("R12 irq dropped", int'(irq_out), 0);
        req_in = 8'h00;
        do_cmd(1, 0);
        chk("R7 isr cleared", int'(isr_out), 0);

        // R2 R5 R8: every level through capture, ack, specific end
        for (int l = 0; l < 8; l++) begin
            rise(l);
            chk("R2 irr latched after line fell", int'(irr_out), 1 << l);
            chk("R2 winner level", int'(win_level), l);
            chk("R2 irq", int'(irq_out), 1);
            do_ack();
            chk("R5 isr bit", int'(isr_out), 1 << l);
            chk("R5 irr bit cleared", int'(irr_out), 0);
            chk("R6 irq low after ack", int'(irq_out), 0);
            do_cmd(2, l);
            chk("R8 isr cleared", int'(isr_out), 0);
        end

        // R6 R7: nested blocking
        do_reset();
        rise(3); do_ack();
        rise(5);
        chk("R6 lower blocked irq", int'(irq_out), 0);
        chk("R6 lower pending", int'(irr_out), 8'h20);
        rise(3);
        chk("R6 equal blocked irq", int'(irq_out), 0);
        rise(1);
        chk("R6 higher raises irq", int'(irq_out), 1);
        chk("R6 higher wins", int'(win_level), 1);
        do_ack();
        chk("R6 nested isr", int'(isr_out), 8'h0A);
        do_cmd(1, 0);
        chk("R7 highest isr cleared", int'(isr_out), 8'h08);
        chk("R7 still blocked", int'(irq_out), 0);
        do_cmd(1, 0);
        chk("R7 last isr cleared", int'(isr_out), 0);
        chk("R7 pending now raises", int'(irq_out), 1);
        chk("R7 winner", int'(win_level), 3);

        // R9: rotate on non-specific end
        do_reset();
        rise(6); do_ack();
        rise(4); do_ack();
        chk("R9 setup isr", int'(isr_out), 8'h50);
        do_cmd(3, 0);
        chk("R9 isr after rotate", int'(isr_out), 8'h40);
        rise(3); rise(5);
        chk("R9 level 5 now highest", int'(win_level), 5);
        chk("R9 level 5 beats in-service 6", int'(irq_out), 1);

        // R10: every pointer position, level mode
        for (int p = 0; p < 8; p++) begin
            int w;
            do_reset();
            level_mode = 1'b1; req_in = 8'hFF;
            do_cmd(5, p);
            w = (p + 1) % 8;
            chk("R10 set priority winner", int'(win_level), w);
            chk("R10 irq", int'(irq_out), 1);
            do_ack();
            chk("R10 isr after ack", int'(isr_out), 1 << w);
            do_cmd(5, (p + 3) % 8);
            chk("R10 set priority keeps isr", int'(isr_out), 1 << w);
            do_cmd(7, p);
            chk("R10 unused code no effect", int'(isr_out), 1 << w);
            do_cmd(4, w);
            chk("R10 rotate specific clears", int'(isr_out), 0);
            chk("R10 rotate specific winner", int'(win_level), (w + 1) % 8);
        end

        // R4: every mask value against all requests
        do_reset();
        level_mode = 1'b1; req_in = 8'hFF;
        step(1);
        for (int m = 0; m < 256; m++) begin
            int ew;
            ew = 0;
            for (int b = 7; b >= 0; b--) if (((m >> b) & 1) == 0) ew = b;
            mask_wr = 1'b1; mask_data = 8'(m); step(1);
            mask_wr = 1'b0; step(1);
            chk("R4 mask irq", int'(irq_out), (m != 255) ? 1 : 0);
            if (m != 255) chk("R4 mask winner", int'(win_level), ew);
        end

        // R3: level mode follows line
        do_reset();
        level_mode = 1'b1;
        req_in = 8'h04; step(1);
        chk("R3 irr follows", int'(irr_out), 8'h04);
        chk("R3 irq not yet", int'(irq_out), 0);
        step(1);
        chk("R3 irq", int'(irq_out), 1);
        chk("R3 winner", int'(win_level), 2);
        req_in = 8'h00; step(1);
        chk("R3 irr dropped", int'(irr_out), 0);
        step(1);
        chk("R3 irq dropped", int'(irq_out), 0);

        // R11: special mask mode
        do_reset();
        rise(2); do_ack();
        rise(6);
        chk("R11 nested blocks lower", int'(irq_out), 0);
        smm = 1'b1; step(2);
        chk("R11 smm lets lower in", int'(irq_out), 1);
        chk("R11 smm winner", int'(win_level), 6);
        do_ack();
        chk("R11 isr both", int'(isr_out), 8'h44);
        rise(2);
        chk("R11 in-service level pending", int'(irr_out), 8'h04);
        chk("R11 in-service level excluded", int'(irq_out), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule